// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets logic running on a single clock read and write an external asynchronous static RAM of 32768 bytes. The host raises a one-cycle request with a direction flag, an address and, for writes, a data byte. The block then runs the memory's active-low select, output-enable and write-strobe lines through a fixed sequence, holding each phase long enough for the memory's minimum timings. At the end it returns a single-cycle completion pulse, with the read byte on `rdata` for reads.

Each timing minimum is a parameter counted in clock cycles. Each value is the nanosecond figure of the chosen speed grade divided by the clock period and rounded up. The defaults suit a 4 ns clock and a 55 ns part: 14 access cycles, a 10-cycle strobe, 7 cycles of data setup and 5 turnaround cycles. The shared memory data bus appears as three separate signals: data out, data in and a driver enable. Every access ends with a turnaround interval, so the controller and the memory are never both driving the bus.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge where `rst` was high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `done` is 0 and `ready` is 1. This also holds when reset arrives in the middle of an access.
- R2: If `req` is 1 while `ready` is 1, the request is accepted at that clock edge and `ready` is 0 in the next cycle. `rw`=1 selects a write and `rw`=0 selects a read.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly T_ACC cycles. `rdata` takes the value of `mem_din` from the last of those cycles.
- R4: `done` is 1 for exactly one cycle per access. For a read this is the cycle after the access phase, and `rdata` is already valid in it. For a write it is the recovery cycle.
- R5: A write runs three phases. First comes one setup cycle with `mem_ce_n`=0, `mem_we_n`=1 and the bus driven. Then comes a strobe phase with `mem_we_n`=0. Last comes one recovery cycle with `mem_we_n`=1 and the bus still driven. `mem_oe_n` stays 1 throughout.
- R6: The strobe phase lasts PW = max(T_WP, T_DS-1, T_ACC-2) cycles. The strobe is therefore at least T_WP cycles long, data is driven at least T_DS cycles before the strobe rises, and the select is low for at least T_ACC cycles.
- R7: `mem_dout_en` is never 1 while the memory may be driving the bus (`mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1). After every access the select stays high for T_TURN cycles before `ready` returns.
- R8: `mem_addr` holds the address latched at acceptance for as long as `mem_ce_n` is 0. `mem_dout` holds the write byte latched at acceptance while `mem_dout_en` is 1. Later changes on `addr` and `wdata` have no effect.
- R9: A `req` that arrives while `ready` is 0 is ignored. While `ready` is 1 and `req` is 0, the memory stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled when ready is 1 |
| rw | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host byte address |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Idle, able to accept a request |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_din | input | 8 | Data returned from the memory bus |
| mem_dout_en | output | 1 | Enable of the controller's bus driver |

## Verification
The hardest case to reach is a sampling point that is off by one cycle. A memory that always returns the right byte hides such an error completely. The bench's memory model therefore returns the complement of the stored byte until its select and output enable have been low for T_ACC falling clock edges, so a capture made one edge early reads wrong data. The same model counts strobe, setup and bus-idle cycles at every write commit. Extra requests are injected during busy phases, host-side address and data are changed right after acceptance, and reset is applied in the middle of a write strobe.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } ctl_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int T_ACC  = 14,
  parameter int T_WP   = 10,
  parameter int T_DS   = 7,
  parameter int T_TURN = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       rw,
  output ctl_state_t nxt_state,
  output logic       accept,
  output logic       capture
);

  localparam int PW_CYC  = imax(imax(T_WP, T_DS - 1), T_ACC - 2);
  localparam int LONGEST = imax(imax(PW_CYC, T_ACC), T_TURN);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ctl_state_t       state;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  always_comb begin
    nxt_state = state;
    ld        = 1'b0;
    ld_val    = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (rw) begin
            nxt_state = ST_WR_SETUP;
          end else begin
            nxt_state = ST_RD_ACC;
            ld_val    = CNT_W'(T_ACC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (expired) begin
          capture   = 1'b1;
          nxt_state = ST_RD_CAP;
        end
      end
      ST_RD_CAP: begin
        nxt_state = ST_TURN;
        ld        = 1'b1;
        ld_val    = CNT_W'(T_TURN - 1);
      end
      ST_WR_SETUP: begin
        nxt_state = ST_WR_PULSE;
        ld        = 1'b1;
        ld_val    = CNT_W'(PW_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (expired) nxt_state = ST_WR_REC;
      end
      ST_WR_REC: begin
        nxt_state = ST_TURN;
        ld        = 1'b1;
        ld_val    = CNT_W'(T_TURN - 1);
      end
      ST_TURN: begin
        if (expired) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt_state;
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_state_t        nxt_state,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dout_en,
  output logic              done,
  output logic              ready
);

  logic sel_nxt, drive_nxt;

  always_comb begin
    sel_nxt   = (nxt_state == ST_RD_ACC)   || (nxt_state == ST_WR_SETUP) ||
                (nxt_state == ST_WR_PULSE) || (nxt_state == ST_WR_REC);
    drive_nxt = (nxt_state == ST_WR_SETUP) || (nxt_state == ST_WR_PULSE) ||
                (nxt_state == ST_WR_REC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout_en <= 1'b0;
      done        <= 1'b0;
      ready       <= 1'b1;
    end else begin
      mem_ce_n    <= !sel_nxt;
      mem_oe_n    <= !(nxt_state == ST_RD_ACC);
      mem_we_n    <= !(nxt_state == ST_WR_PULSE);
      mem_dout_en <= drive_nxt;
      done        <= (nxt_state == ST_RD_CAP) || (nxt_state == ST_WR_REC);
      ready       <= (nxt_state == ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dout <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr_in;
        mem_dout <= wdata_in;
      end
      if (capture) rdata <= mem_din;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int T_ACC  = 14,
  parameter int T_WP   = 10,
  parameter int T_DS   = 7,
  parameter int T_TURN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ready,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dout_en
);

  ctl_state_t nxt_state;
  logic       accept, capture;

  sram_ctl_fsm #(
    .T_ACC (T_ACC),
    .T_WP  (T_WP),
    .T_DS  (T_DS),
    .T_TURN(T_TURN)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .rw       (rw),
    .nxt_state(nxt_state),
    .accept   (accept),
    .capture  (capture)
  );

  sram_pin_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .nxt_state  (nxt_state),
    .accept     (accept),
    .capture    (capture),
    .addr_in    (addr),
    .wdata_in   (wdata),
    .mem_din    (mem_din),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .rdata      (rdata),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout_en(mem_dout_en),
    .done       (done),
    .ready      (ready)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              done,
  input logic              ready,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_en
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && !done && ready));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && req) |=> (!ready && !mem_ce_n));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_strobe_selected_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    mem_dout_en |-> mem_oe_n);

  p_addr_held_r8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_data_held_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

  p_idle_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !req) |=> (ready && mem_ce_n));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .done       (done),
  .ready      (ready),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .mem_dout   (mem_dout),
  .mem_dout_en(mem_dout_en)
);

// File: tb/sim_sram_async_ctl.sv
module sim_sram_async_ctl;

  localparam int ACC  = 14;
  localparam int WP   = 10;
  localparam int DS   = 7;
  localparam int TURN = 5;
  localparam int PW   = (WP > DS - 1) ? ((WP > ACC - 2) ? WP : ACC - 2)
                                      : ((DS - 1 > ACC - 2) ? DS - 1 : ACC - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        rw = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done, ready;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dout;
  logic [7:0]  mem_din = '0;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  sram_async_ctl #(
    .ADDR_W(15), .DATA_W(8), .T_ACC(ACC), .T_WP(WP), .T_DS(DS), .T_TURN(TURN)
  ) u0 (
    .clk(clk), .rst(rst), .req(req), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .ready(ready),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_dout_en(mem_dout_en)
  );

  // Memory contents as seen by the pins, and as the host intends them.
  logic [7:0] pin_mem [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] blank_val(input logic [14:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] pin_read(input logic [14:0] a);
    if (pin_mem.exists(int'(a))) return pin_mem[int'(a)];
    return blank_val(a);
  endfunction

  function automatic logic [7:0] ref_read(input logic [14:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return blank_val(a);
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Behavioural memory: data is wrong until access time has elapsed.
  int  acc_cnt = 0, wp_cnt = 0, ds_cnt = 0, idle_cnt = 100;
  bit  prev_we_n = 1'b1, prev_den = 1'b0, mem_drv = 1'b0;

  always @(negedge clk) begin
    mem_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (mem_drv) acc_cnt++; else acc_cnt = 0;
    mem_din <= mem_drv ? ((acc_cnt >= ACC) ? pin_read(mem_addr) : ~pin_read(mem_addr))
                       : 8'h00;
    if (!rst) begin
      if (mem_dout_en && mem_drv) chk("R7", "bus contention", 1, 0);
      if (mem_dout_en && !prev_den) chk("R7", "turnaround before drive",
                                        32'(idle_cnt >= TURN), 1);
      if (mem_we_n && !prev_we_n && !mem_ce_n) begin
        chk("R6", "strobe width", 32'(wp_cnt >= WP), 1);
        chk("R6", "data setup", 32'(ds_cnt >= DS), 1);
        pin_mem[int'(mem_addr)] = mem_dout;
      end
    end
    if (!mem_we_n && !mem_ce_n) wp_cnt++; else wp_cnt = 0;
    if (mem_dout_en) ds_cnt++; else ds_cnt = 0;
    if (!mem_drv && !mem_dout_en) idle_cnt++; else idle_cnt = 0;
    prev_we_n = mem_we_n;
    prev_den  = mem_dout_en;
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic pins_exp(input string rq, input bit ce, input bit oe, input bit we,
                          input bit den, input bit dn, input bit rdy);
    chk(rq, "pins ce/oe/we/den/done/ready",
        {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, done, ready},
        {26'd0, ce, oe, we, den, dn, rdy});
  endtask

  // One access, checked cycle by cycle. Caller is at a negedge with ready.
  task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        input bit poke);
    int last;
    chk("R2", "ready before request", 32'(ready), 1);
    req = 1'b1; rw = wr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~d;
    if (wr) ref_mem[int'(a)] = d;
    last = wr ? (3 + PW + TURN) : (2 + ACC + TURN);
    for (int j = 1; j <= last; j++) begin
      if (wr) begin
        if (j == 1)                  pins_exp("R5", 0, 1, 1, 1, 0, 0);
        else if (j <= 1 + PW)        pins_exp("R6", 0, 1, 0, 1, 0, 0);
        else if (j == 2 + PW)        pins_exp("R4", 0, 1, 1, 1, 1, 0);
        else if (j < last)           pins_exp("R7", 1, 1, 1, 0, 0, 0);
        else                         pins_exp("R7", 1, 1, 1, 0, 0, 1);
        if (j <= 2 + PW) begin
          chk("R8", "write address held", 32'(mem_addr), 32'(a));
          chk("R8", "write data held", 32'(mem_dout), 32'(d));
        end
      end else begin
        if (j <= ACC) begin
          pins_exp("R3", 0, 0, 1, 0, 0, 0);
          chk("R8", "read address held", 32'(mem_addr), 32'(a));
        end else if (j == ACC + 1) begin
          pins_exp("R4", 1, 1, 1, 0, 1, 0);
          chk("R3", "read data", 32'(rdata), 32'(ref_read(a)));
        end else if (j < last)       pins_exp("R7", 1, 1, 1, 0, 0, 0);
        else                         pins_exp("R7", 1, 1, 1, 0, 0, 1);
      end
      if (poke && j >= 2 && j <= 5) begin
        req = 1'b1; rw = ~wr; addr = a ^ 15'h0F0F; wdata = 8'hC3;
      end else begin
        req = 1'b0;
      end
      if (j < last) @(negedge clk);
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pins_exp("R1", 1, 1, 1, 0, 0, 1);
    rst = 1'b0;
    @(negedge clk);
    pins_exp("R1", 1, 1, 1, 0, 0, 1);

    run_op(1'b1, 15'h0000, 8'h5A, 1'b0);
    run_op(1'b1, 15'h7FFF, 8'hFF, 1'b0);
    run_op(1'b1, 15'h1234, 8'h00, 1'b0);
    run_op(1'b0, 15'h0000, 8'h00, 1'b0);
    run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    run_op(1'b0, 15'h1234, 8'h00, 1'b0);
    run_op(1'b0, 15'h0101, 8'h00, 1'b0);

    // R9: busy requests ignored, then idle holds without a request.
    run_op(1'b1, 15'h2AAA, 8'hA7, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pins_exp("R9", 1, 1, 1, 0, 0, 1);
    end
    chk("R9", "poked address untouched", 32'(pin_read(15'h2AAA ^ 15'h0F0F)),
        32'(blank_val(15'h2AAA ^ 15'h0F0F)));
    @(negedge clk);
    run_op(1'b0, 15'h2AAA, 8'h00, 1'b1);
    @(negedge clk);
    pins_exp("R9", 1, 1, 1, 0, 0, 1);

    // R1: reset in the middle of a write strobe.
    req = 1'b1; rw = 1'b1; addr = 15'h4444; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    pins_exp("R5", 0, 1, 0, 1, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    pins_exp("R1", 1, 1, 1, 0, 0, 1);
    rst = 1'b0;
    @(negedge clk);
    pins_exp("R1", 1, 1, 1, 0, 0, 1);

    run_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    run_op(1'b1, 15'h0001, 8'h3E, 1'b0);
    run_op(1'b0, 15'h0001, 8'h00, 1'b0);
    finish_run();
  end

endmodule